// File: doc/BRIEF.md
# Accumulator-Pair Multiply/Divide Unit

This block is the multicycle arithmetic unit that sits beside the register file of an 8-bit processor core. It has two operations, and both are bound to fixed registers. A multiply takes the high register and the low register of the accumulator pair as its two unsigned factors. The 16-bit product replaces the whole pair. A divide treats the pair as one unsigned 16-bit dividend and divides it by the divisor register. The quotient goes to the low half of the pair and the remainder goes to the high half.

The core raises `start_i` for one cycle with `op_div_i` and the three register values. Each operation then takes a fixed number of cycles. At the end, `done_o` pulses once together with the new pair values, the status-flag values and the per-flag update enables. The core writes these into its registers and flag word. A multiply only touches the negative and zero flags. A divide also reports a quotient-overflow flag and a nibble-compare flag. Divisions whose quotient cannot fit in one byte, divide by zero among them, end in a fixed, defined pattern. They never stall.

Top module: `pair_muldiv`

## Requirements
- R1: With `op_div_i`=0, the unit multiplies `hi_i` by `lo_i` as unsigned 8-bit values. The 16-bit product appears as `{hi_o, lo_o}`, with the high byte in `hi_o`.
- R2: With `op_div_i`=1 and `hi_i` < `dsr_i`, `lo_o` receives the quotient of `{hi_i, lo_i}` divided by `dsr_i` and `hi_o` receives the remainder.
- R3: With `op_div_i`=1 and `hi_i` >= `dsr_i`, which includes `dsr_i`=0, `lo_o` becomes 8'hFF. `hi_o` becomes `(lo_i + dsr_i)` mod 256, which is the low byte of `{hi_i,lo_i}` minus 255 times `dsr_i`. The operation completes on time.
- R4: `done_o` rises exactly 9 rising edges after the edge that samples an accepted multiply start, and exactly 12 after the edge that samples an accepted divide start.
- R5: At the end of a multiply, `nz_upd_o`=1 and `vh_upd_o`=0. `flag_neg_o` equals bit 7 of `hi_o`, and `flag_zero_o` is 1 exactly when `hi_o` is 0.
- R6: At the end of a divide, `nz_upd_o`=1 and `vh_upd_o`=1. `flag_neg_o` equals bit 7 of `lo_o` and `flag_zero_o` is 1 exactly when `lo_o` is 0. `flag_ovf_o` is 1 exactly when `hi_i` >= `dsr_i`. `flag_half_o` is 1 exactly when `hi_i[3:0]` >= `dsr_i[3:0]`.
- R7: A `start_i` that arrives while an operation is in progress is ignored. The running operation keeps its operands and its timing, and no extra `done_o` follows. A new start is accepted from the first edge after `done_o` is seen.
- R8: `done_o` is high for exactly one cycle. `nz_upd_o` and `vh_upd_o` are high only in that cycle. `hi_o` and `lo_o` change only in a `done_o` cycle and otherwise hold their values.
- R9: While `rst_n` is low and after its release, until the first `done_o`, `hi_o`, `lo_o`, all four flags, both update enables and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Operation request, sampled on a rising edge |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| hi_i | input | 8 | High register of the pair (multiplicand / dividend high byte) |
| lo_i | input | 8 | Low register of the pair (multiplier / dividend low byte) |
| dsr_i | input | 8 | Divisor register |
| hi_o | output | 8 | New high register value (product high / remainder) |
| lo_o | output | 8 | New low register value (product low / quotient) |
| flag_neg_o | output | 1 | Negative flag value |
| flag_ovf_o | output | 1 | Quotient-overflow flag value |
| flag_half_o | output | 1 | Nibble-compare flag value |
| flag_zero_o | output | 1 | Zero flag value |
| nz_upd_o | output | 1 | Write enable for negative and zero flags |
| vh_upd_o | output | 1 | Write enable for overflow and nibble flags |
| done_o | output | 1 | One-cycle completion pulse, coincident with results |

## Verification
The bench uses divisor values on both sides of the overflow boundary: high byte one below the divisor, equal to the divisor, and a zero divisor. A unit that compares with the wrong sense, or that lets a zero divisor into the loop, would return a bogus quotient or never finish. It uses multiplies with a zero high product and a nonzero low byte, to catch a zero flag taken from the wrong byte or from the whole product. It also uses nibble pairs that are equal, below and above, to catch a half flag computed with a strict comparison. Requests are fired mid-operation with different operands. A unit that restarted or latched them would show a shifted done time, changed results or an extra pulse. Operations are chained back to back, so a unit that stays busy one cycle too long would drop the next request.

// File: rtl/pmd_pkg.sv
`timescale 1ns/1ps
package pmd_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } pmd_op_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic half;
    logic zero;
  } pmd_flags_t;

endpackage

// File: rtl/pmd_ctrl.sv
`timescale 1ns/1ps
// Operation sequencer: accepts a request when idle, issues one step per
// cycle for the iterative datapaths, and marks the final cycle of the
// operation's fixed latency.
module pmd_ctrl
  import pmd_pkg::*;
#(
  parameter int STEPS      = 8,
  parameter int MUL_CYCLES = 9,
  parameter int DIV_CYCLES = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  pmd_op_e op_i,
  output logic    load_o,
  output logic    step_o,
  output logic    finish_o,
  output pmd_op_e op_o
);

  localparam int MAXC = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_CYCLES);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_CYCLES);
  localparam logic [CW-1:0] STEP_MAX = CW'(STEPS);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  pmd_op_e       op_q, op_d;
  logic [CW-1:0] last_cnt;

  always_comb begin
    last_cnt = (op_q == OP_DIV) ? DIV_LAST : MUL_LAST;
    load_o   = start_i & ~busy_q;
    finish_o = busy_q & (cnt_q == last_cnt);
    step_o   = busy_q & (cnt_q <= STEP_MAX);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = CW'(1);
      op_d   = op_i;
    end else if (finish_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
    end
  end

  assign op_o = op_q;

endmodule

// File: rtl/pmd_mul.sv
`timescale 1ns/1ps
// Shift-add unsigned multiplier, one multiplier bit per step.
module pmd_mul #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] mcand_i,
  input  logic [DW-1:0] mplier_i,
  output logic [2*DW-1:0] prod_o
);

  logic [DW-1:0] hi_q, hi_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [DW-1:0] mc_q, mc_d;
  logic [DW:0]   sum;

  always_comb begin
    sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : {(DW+1){1'b0}});
    hi_d = hi_q;
    lo_d = lo_q;
    mc_d = mc_q;
    if (load_i) begin
      hi_d = '0;
      lo_d = mplier_i;
      mc_d = mcand_i;
    end else if (step_i) begin
      hi_d = sum[DW:1];
      lo_d = {sum[0], lo_q[DW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      mc_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      mc_q <= mc_d;
    end
  end

  assign prod_o = {hi_q, lo_q};

endmodule

// File: rtl/pmd_div.sv
`timescale 1ns/1ps
// Restoring shift-subtract divider for a double-width dividend, one
// quotient bit per step. Dividends whose quotient would not fit in DW
// bits (including a zero divisor) bypass the loop with a fixed pattern.
module pmd_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] dvd_hi_i,
  input  logic [DW-1:0] dvd_lo_i,
  input  logic [DW-1:0] dsr_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          ovf_o,
  output logic          half_o
);

  localparam int HW = DW / 2;

  logic [DW-1:0] rem_q, rem_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [DW-1:0] dsr_q, dsr_d;
  logic [DW-1:0] lo_keep_q, lo_keep_d;
  logic          ovf_q, ovf_d;
  logic          half_q, half_d;
  logic [DW:0]   trial;
  logic [DW:0]   trial_diff;
  logic          fits;

  always_comb begin
    trial      = {rem_q, quo_q[DW-1]};
    trial_diff = trial - {1'b0, dsr_q};
    fits       = (trial >= {1'b0, dsr_q});

    rem_d     = rem_q;
    quo_d     = quo_q;
    dsr_d     = dsr_q;
    lo_keep_d = lo_keep_q;
    ovf_d     = ovf_q;
    half_d    = half_q;
    if (load_i) begin
      rem_d     = dvd_hi_i;
      quo_d     = dvd_lo_i;
      dsr_d     = dsr_i;
      lo_keep_d = dvd_lo_i;
      ovf_d     = (dvd_hi_i >= dsr_i);
      half_d    = (dvd_hi_i[HW-1:0] >= dsr_i[HW-1:0]);
    end else if (step_i) begin
      rem_d = fits ? trial_diff[DW-1:0] : trial[DW-1:0];
      quo_d = {quo_q[DW-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      quo_q     <= '0;
      dsr_q     <= '0;
      lo_keep_q <= '0;
      ovf_q     <= 1'b0;
      half_q    <= 1'b0;
    end else begin
      rem_q     <= rem_d;
      quo_q     <= quo_d;
      dsr_q     <= dsr_d;
      lo_keep_q <= lo_keep_d;
      ovf_q     <= ovf_d;
      half_q    <= half_d;
    end
  end

  // Overflow pattern: quotient all ones; remainder is the low word of
  // dividend - (2^DW - 1) * divisor, which reduces to low + divisor.
  always_comb begin
    if (ovf_q) begin
      quo_o = '1;
      rem_o = lo_keep_q + dsr_q;
    end else begin
      quo_o = quo_q;
      rem_o = rem_q;
    end
  end

  assign ovf_o  = ovf_q;
  assign half_o = half_q;

endmodule

// File: rtl/pair_muldiv.sv
`timescale 1ns/1ps
// Accumulator-pair multiply/divide unit (top).
module pair_muldiv
  import pmd_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MUL_CYCLES = 9,
  parameter int DIV_CYCLES = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_div_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] dsr_i,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o,
  output logic          flag_neg_o,
  output logic          flag_ovf_o,
  output logic          flag_half_o,
  output logic          flag_zero_o,
  output logic          nz_upd_o,
  output logic          vh_upd_o,
  output logic          done_o
);

  logic          load, step, finish;
  pmd_op_e       op_run;
  logic          mul_step, div_step;
  logic [2*DW-1:0] prod;
  logic [DW-1:0] quo, rem;
  logic          div_ovf, div_half;

  pmd_ctrl #(
    .STEPS      (DW),
    .MUL_CYCLES (MUL_CYCLES),
    .DIV_CYCLES (DIV_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (pmd_op_e'(op_div_i)),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .op_o     (op_run)
  );

  assign mul_step = step & (op_run == OP_MUL);
  assign div_step = step & (op_run == OP_DIV);

  pmd_mul #(.DW(DW)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (mul_step),
    .mcand_i  (hi_i),
    .mplier_i (lo_i),
    .prod_o   (prod)
  );

  pmd_div #(.DW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (div_step),
    .dvd_hi_i (hi_i),
    .dvd_lo_i (lo_i),
    .dsr_i    (dsr_i),
    .quo_o    (quo),
    .rem_o    (rem),
    .ovf_o    (div_ovf),
    .half_o   (div_half)
  );

  // Result stage
  logic [DW-1:0] hi_q, hi_d, lo_q, lo_d;
  pmd_flags_t    fl_q, fl_d;
  logic          done_q, done_d, nz_q, nz_d, vh_q, vh_d;

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    fl_d   = fl_q;
    done_d = 1'b0;
    nz_d   = 1'b0;
    vh_d   = 1'b0;
    if (finish) begin
      done_d = 1'b1;
      nz_d   = 1'b1;
      if (op_run == OP_DIV) begin
        vh_d        = 1'b1;
        hi_d        = rem;
        lo_d        = quo;
        fl_d.neg    = quo[DW-1];
        fl_d.zero   = (quo == '0);
        fl_d.ovf    = div_ovf;
        fl_d.half   = div_half;
      end else begin
        hi_d        = prod[2*DW-1:DW];
        lo_d        = prod[DW-1:0];
        fl_d.neg    = prod[2*DW-1];
        fl_d.zero   = (prod[2*DW-1:DW] == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      fl_q   <= '0;
      done_q <= 1'b0;
      nz_q   <= 1'b0;
      vh_q   <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      fl_q   <= fl_d;
      done_q <= done_d;
      nz_q   <= nz_d;
      vh_q   <= vh_d;
    end
  end

  assign hi_o        = hi_q;
  assign lo_o        = lo_q;
  assign flag_neg_o  = fl_q.neg;
  assign flag_ovf_o  = fl_q.ovf;
  assign flag_half_o = fl_q.half;
  assign flag_zero_o = fl_q.zero;
  assign nz_upd_o    = nz_q;
  assign vh_upd_o    = vh_q;
  assign done_o      = done_q;

endmodule

// File: rtl/pmd_check.sv
`timescale 1ns/1ps
// Port-level checker: tracks accepted requests independently and checks
// timing and results of each completion.
module pmd_check #(
  parameter int DW         = 8,
  parameter int MUL_CYCLES = 9,
  parameter int DIV_CYCLES = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          op_div_i,
  input logic [DW-1:0] hi_i,
  input logic [DW-1:0] lo_i,
  input logic [DW-1:0] dsr_i,
  input logic [DW-1:0] hi_o,
  input logic [DW-1:0] lo_o,
  input logic          flag_neg_o,
  input logic          flag_ovf_o,
  input logic          flag_half_o,
  input logic          flag_zero_o,
  input logic          nz_upd_o,
  input logic          vh_upd_o,
  input logic          done_o
);

  localparam int MAXC = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;
  localparam int CW   = $clog2(MAXC + 2) + 1;
  localparam int HW   = DW / 2;
  localparam logic [CW-1:0] MUL_SEEN = CW'(MUL_CYCLES + 1);
  localparam logic [CW-1:0] DIV_SEEN = CW'(DIV_CYCLES + 1);

  logic          busy_c, div_c, accept_c;
  logic [CW-1:0] cnt_c;
  logic [DW-1:0] hi_c, lo_c, dsr_c;

  assign accept_c = start_i && (!busy_c || done_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      div_c  <= 1'b0;
      cnt_c  <= '0;
      hi_c   <= '0;
      lo_c   <= '0;
      dsr_c  <= '0;
    end else if (accept_c) begin
      busy_c <= 1'b1;
      div_c  <= op_div_i;
      cnt_c  <= CW'(1);
      hi_c   <= hi_i;
      lo_c   <= lo_i;
      dsr_c  <= dsr_i;
    end else if (done_o) begin
      busy_c <= 1'b0;
    end else if (busy_c) begin
      cnt_c  <= cnt_c + 1'b1;
    end
  end

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_c) |-> ({hi_o, lo_o} == ((2*DW)'(hi_c) * (2*DW)'(lo_c))));

  p_quot_rem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_c && !flag_ovf_o) |->
      ((hi_o < dsr_c) &&
       (((2*DW)'(lo_o) * (2*DW)'(dsr_c) + (2*DW)'(hi_o)) == {hi_c, lo_c})));

  p_overflow_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_c && flag_ovf_o) |-> ((lo_o == '1) && (hi_o == DW'(lo_c + dsr_c))));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_c && (cnt_c == (div_c ? DIV_SEEN : MUL_SEEN))));

  p_mul_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_c) |->
      (nz_upd_o && !vh_upd_o && (flag_neg_o == hi_o[DW-1]) && (flag_zero_o == (hi_o == '0))));

  p_div_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_c) |->
      (nz_upd_o && vh_upd_o && (flag_neg_o == lo_o[DW-1]) && (flag_zero_o == (lo_o == '0)) &&
       (flag_ovf_o == (hi_c >= dsr_c)) && (flag_half_o == (hi_c[HW-1:0] >= dsr_c[HW-1:0]))));

  p_done_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_c);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_upd_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_upd_o || vh_upd_o) |-> done_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));

endmodule

bind pair_muldiv pmd_check #(
  .DW         (DW),
  .MUL_CYCLES (MUL_CYCLES),
  .DIV_CYCLES (DIV_CYCLES)
) u_pmd_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .op_div_i    (op_div_i),
  .hi_i        (hi_i),
  .lo_i        (lo_i),
  .dsr_i       (dsr_i),
  .hi_o        (hi_o),
  .lo_o        (lo_o),
  .flag_neg_o  (flag_neg_o),
  .flag_ovf_o  (flag_ovf_o),
  .flag_half_o (flag_half_o),
  .flag_zero_o (flag_zero_o),
  .nz_upd_o    (nz_upd_o),
  .vh_upd_o    (vh_upd_o),
  .done_o      (done_o)
);

// File: tb/test_pair_muldiv.sv
`timescale 1ns/1ps
module test_pair_muldiv;

  localparam int MUL_LAT = 9;
  localparam int DIV_LAT = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       op_div_i = 1'b0;
  logic [7:0] hi_i = '0, lo_i = '0, dsr_i = '0;
  logic [7:0] hi_o, lo_o;
  logic       flag_neg_o, flag_ovf_o, flag_half_o, flag_zero_o;
  logic       nz_upd_o, vh_upd_o, done_o;

  pair_muldiv i_pair_muldiv (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_div_i    (op_div_i),
    .hi_i        (hi_i),
    .lo_i        (lo_i),
    .dsr_i       (dsr_i),
    .hi_o        (hi_o),
    .lo_o        (lo_o),
    .flag_neg_o  (flag_neg_o),
    .flag_ovf_o  (flag_ovf_o),
    .flag_half_o (flag_half_o),
    .flag_zero_o (flag_zero_o),
    .nz_upd_o    (nz_upd_o),
    .vh_upd_o    (vh_upd_o),
    .done_o      (done_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int unsigned due;
    bit          is_div;
    logic [7:0]  hi;
    logic [7:0]  lo;
    bit          n, v, h, z;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          prev_done = 1'b0;
  logic [7:0]  last_hi = '0, last_lo = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input bit is_div, input logic [7:0] hi, input logic [7:0] lo,
                                 input logic [7:0] dv);
    exp_t        e;
    logic [15:0] p;
    logic [15:0] q;
    logic [15:0] r;
    e.is_div = is_div;
    e.due = 0;
    if (!is_div) begin
      p    = {8'h00, hi} * {8'h00, lo};
      e.hi = p[15:8];
      e.lo = p[7:0];
      e.n  = e.hi[7];
      e.z  = (e.hi == 8'h00);
      e.v  = 1'b0;
      e.h  = 1'b0;
    end else begin
      e.v = (hi >= dv);
      e.h = (hi[3:0] >= dv[3:0]);
      if (e.v) begin
        e.lo = 8'hFF;
        e.hi = lo + dv;
      end else begin
        p    = {hi, lo};
        q    = p / {8'h00, dv};
        r    = p % {8'h00, dv};
        e.lo = q[7:0];
        e.hi = r[7:0];
      end
      e.n = e.lo[7];
      e.z = (e.lo == 8'h00);
    end
    return e;
  endfunction

  // Driver: issues one request; optional mid-run request that must be ignored.
  // Returns one negedge before the done cycle so the next request is back to back.
  task automatic run_op(input bit is_div, input logic [7:0] hi, input logic [7:0] lo,
                        input logic [7:0] dv, input bit poke);
    exp_t e;
    int   lat;
    lat = is_div ? DIV_LAT : MUL_LAT;
    e   = model(is_div, hi, lo, dv);
    @(negedge clk);
    start_i  = 1'b1;
    op_div_i = is_div;
    hi_i = hi; lo_i = lo; dsr_i = dv;
    e.due = cyc + 1 + lat;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    hi_i = 8'h5A; lo_i = 8'hA5; dsr_i = 8'h3C;
    if (poke) begin
      // R7: request while busy with other operands and opposite operation
      repeat (3) @(negedge clk);
      start_i  = 1'b1;
      op_div_i = ~is_div;
      hi_i = ~hi; lo_i = ~lo; dsr_i = ~dv;
      @(negedge clk);
      start_i = 1'b0;
      repeat (lat - 5) @(negedge clk);
    end else begin
      repeat (lat - 1) @(negedge clk);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R7 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          string rq;
          e  = sb.pop_front();
          rq = !e.is_div ? "R1" : (e.v ? "R3" : "R2");
          check("R4", "done cycle", int'(cyc), int'(e.due));
          check(rq, "hi_o", int'(hi_o), int'(e.hi));
          check(rq, "lo_o", int'(lo_o), int'(e.lo));
          if (!e.is_div) begin
            check("R5", "nz_upd", int'(nz_upd_o), 1);
            check("R5", "vh_upd", int'(vh_upd_o), 0);
            check("R5", "neg", int'(flag_neg_o), int'(e.n));
            check("R5", "zero", int'(flag_zero_o), int'(e.z));
          end else begin
            check("R6", "nz_upd", int'(nz_upd_o), 1);
            check("R6", "vh_upd", int'(vh_upd_o), 1);
            check("R6", "neg", int'(flag_neg_o), int'(e.n));
            check("R6", "zero", int'(flag_zero_o), int'(e.z));
            check("R6", "ovf", int'(flag_ovf_o), int'(e.v));
            check("R6", "half", int'(flag_half_o), int'(e.h));
          end
          last_hi = e.hi;
          last_lo = e.lo;
        end
      end else begin
        if (nz_upd_o || vh_upd_o) begin
          checks++; fails++;
          $display("FAIL R8 update enable outside done actual=1 expected=0");
        end
      end
      if (done_o && prev_done) begin
        checks++; fails++;
        $display("FAIL R8 done longer than one cycle actual=2 expected=1");
      end
      prev_done = done_o;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=timeout expected=end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    check("R9", "done in reset", int'(done_o), 0);
    check("R9", "hi in reset", int'(hi_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: after release, before any operation
    check("R9", "done", int'(done_o), 0);
    check("R9", "hi_o", int'(hi_o), 0);
    check("R9", "lo_o", int'(lo_o), 0);
    check("R9", "flags", int'({flag_neg_o, flag_ovf_o, flag_half_o, flag_zero_o}), 0);
    check("R9", "upd", int'({nz_upd_o, vh_upd_o}), 0);

    // R1/R5 multiplies
    run_op(1'b0, 8'h12, 8'h34, 8'h00, 1'b0);
    run_op(1'b0, 8'hFF, 8'hFF, 8'h00, 1'b0);  // negative high byte
    run_op(1'b0, 8'h00, 8'h37, 8'h00, 1'b0);  // zero product
    run_op(1'b0, 8'h01, 8'hFF, 8'h00, 1'b0);  // R5: high zero, low nonzero
    run_op(1'b0, 8'h80, 8'h02, 8'h00, 1'b0);
    // R2/R6 divides
    run_op(1'b1, 8'h01, 8'h23, 8'h10, 1'b0);
    run_op(1'b1, 8'h00, 8'hFF, 8'h01, 1'b0);  // quotient FF, half clear
    run_op(1'b1, 8'h00, 8'h00, 8'h05, 1'b0);  // zero quotient
    run_op(1'b1, 8'h7F, 8'hFF, 8'h80, 1'b0);  // high one below divisor
    run_op(1'b1, 8'h03, 8'hE8, 8'h0A, 1'b0);
    // R3 overflow and zero divisor
    run_op(1'b1, 8'h12, 8'h34, 8'h00, 1'b0);
    run_op(1'b1, 8'h50, 8'h11, 8'h20, 1'b0);
    run_op(1'b1, 8'h40, 8'hF0, 8'h40, 1'b0);  // equal: overflow
    // R7 ignored requests while busy
    run_op(1'b0, 8'h9C, 8'h41, 8'h00, 1'b1);
    run_op(1'b1, 8'h05, 8'h77, 8'h09, 1'b1);
    // let last complete, then idle
    repeat (2) @(negedge clk);
    repeat (6) @(negedge clk);
    // R8: results held while idle
    check("R8", "hi_o held", int'(hi_o), int'(last_hi));
    check("R8", "lo_o held", int'(lo_o), int'(last_lo));
    // R7: every accepted request completed, nothing extra
    check("R7", "pending items", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule